// File: doc/BRIEF.md
# Tightly-Coupled Memory Address Decoder

This block keeps the placement state of two tightly-coupled memories that sit beside a processor core: an instruction memory that always starts at address zero, and a data memory that can be moved to any base aligned to its own size. The processor writes a control word carrying one enable bit per memory, plus one setting word per memory whose five-bit field at bits 5:1 picks the window size as 512 bytes shifted left by that field. From these the block works out an upper limit for the instruction window and a base and mask pair for the data window.

For every access the block aligns the address to the access width and decides whether it lands in the instruction memory, in the data memory or in neither. On a hit it gives the byte offset into the physical array, which repeats through a window larger than the array, and raises a one-cycle indication. The instruction memory is checked first and wins when both windows cover an address. Code fetches are only ever checked against the instruction memory. The memory arrays and the slow bus path taken on a miss are built elsewhere.

Top module: `tcm_decoder`

## Requirements
- R1: With control bit 18 set, the instruction window spans addresses 0 up to (but not including) 512 << F, where F is bits 5:1 of the instruction setting word; an aligned address at or above that limit does not hit the instruction memory.
- R2: With control bit 18 clear, no address hits the instruction memory.
- R3: The data window size is 512 << F (F from bits 5:1 of the data setting word) raised to at least 4096 bytes; its base is the setting word with all bits below the window size (and at least bits 11:0) cleared, and an aligned address hits only when the address with those bits cleared equals the base.
- R4: With control bit 16 clear, no address hits the data memory.
- R5: A data setting write keeps only bits 31:12 and 5:1 of the written word, and an instruction setting write keeps only bits 5:1; the kept value is visible on the setting outputs.
- R6: When an aligned address lies in both windows, only the instruction hit is raised.
- R7: On a hit, the offset output equals the aligned address modulo the physical size of the memory hit (32768 bytes for instruction, 16384 bytes for data by default), so the array repeats through the window.
- R8: Access size code 0 is a byte and leaves the address as is, code 1 is a halfword and clears bit 0, code 2 is a word and clears bits 1:0; the clearing happens before both the window test and the offset.
- R9: A code fetch (acc_code high) never hits the data memory.
- R10: The one-cycle indication is high exactly when either hit is high, and with acc_valid low neither hit nor the indication is raised.
- R11: A control or setting write changes the decode from the clock edge that captures it onward; before that edge the old placement still applies.
- R12: The window size is computed in 32 bits: an instruction field of 23 or more yields an empty window, and a data field of 23 or more yields the 4096-byte minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; both memories disabled, settings zero |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word; bit 16 enables data memory, bit 18 instruction memory |
| dset_wr | input | 1 | Data setting write strobe |
| iset_wr | input | 1 | Instruction setting write strobe |
| set_wdata | input | 32 | Write data for either setting word |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_code | input | 1 | High for a code fetch, low for a data access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | input | 32 | Access address |
| itcm_hit | output | 1 | Access lands in the instruction memory |
| dtcm_hit | output | 1 | Access lands in the data memory |
| itcm_off | output | 15 | Byte offset into the instruction array |
| dtcm_off | output | 14 | Byte offset into the data array |
| one_cycle | output | 1 | Access completes in a single cycle |
| dset_q | output | 32 | Kept data setting word |
| iset_q | output | 32 | Kept instruction setting word |

## Verification
The hardest situations to reach are those where both windows overlap and the size field runs past the 32-bit range, since they need a particular sequence of control and setting writes before any access can show them. The bench places the data memory at base zero under an enabled instruction window to force the overlap, then programs fields of 23 and 31 to reach the wrapped sizes, and probes addresses one step either side of every window edge. Write timing is checked by presenting an address in the new window during the very cycle of the write and sampling both before and after the capturing edge.

// File: rtl/tcm_dec_pkg.sv
package tcm_dec_pkg;
   localparam int ADDR_W = 32;

   typedef logic [ADDR_W-1:0] addr_t;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_WORD = 2'd2
   } acc_size_e;

   typedef struct packed {
      addr_t base;
      addr_t mask;
      addr_t limit;
   } win_t;
endpackage

// File: rtl/tcm_align.sv
module tcm_align
   import tcm_dec_pkg::*;
(
   input  addr_t      addr_i,
   input  logic [1:0] size_i,
   output addr_t      addr_o
);
   always_comb begin
      unique case (size_i)
         ACC_HALF: addr_o = {addr_i[ADDR_W-1:1], 1'b0};
         ACC_WORD: addr_o = {addr_i[ADDR_W-1:2], 2'b00};
         default:  addr_o = addr_i;
      endcase
   end
endmodule

// File: rtl/tcm_geom.sv
module tcm_geom
   import tcm_dec_pkg::*;
#(
   parameter bit          IS_DATA    = 1'b0,
   parameter int unsigned UNIT_BYTES = 512,
   parameter int unsigned MIN_BYTES  = 4096,
   parameter int unsigned FIELD_LSB  = 1,
   parameter int unsigned FIELD_W    = 5
) (
   input  logic  en_i,
   input  addr_t setting_i,
   output win_t  win_o
);
   localparam addr_t UNIT     = addr_t'(UNIT_BYTES);
   localparam addr_t MIN_SZ   = addr_t'(MIN_BYTES);
   localparam addr_t LOW_KEEP = ~(MIN_SZ - addr_t'(1));

   logic [FIELD_W-1:0] fld;
   addr_t              raw_sz;

   assign fld    = setting_i[FIELD_LSB +: FIELD_W];
   assign raw_sz = UNIT << fld;

   generate
      if (IS_DATA) begin : g_data
         addr_t sz;
         addr_t msk;
         assign sz  = (raw_sz < MIN_SZ) ? MIN_SZ : raw_sz;
         assign msk = LOW_KEEP & ~(sz - addr_t'(1));
         always_comb begin
            win_o.limit = '0;
            if (en_i) begin
               win_o.mask = msk;
               win_o.base = setting_i & msk;
            end else begin
               win_o.mask = '0;
               win_o.base = '1;
            end
         end
      end else begin : g_instr
         always_comb begin
            win_o.base  = '0;
            win_o.mask  = '0;
            win_o.limit = en_i ? raw_sz : '0;
         end
      end
   endgenerate
endmodule

// File: rtl/tcm_decoder.sv
module tcm_decoder
   import tcm_dec_pkg::*;
#(
   parameter int unsigned I_PHYS_BYTES = 32768,
   parameter int unsigned D_PHYS_BYTES = 16384,
   parameter int unsigned D_EN_BIT     = 16,
   parameter int unsigned I_EN_BIT     = 18,
   parameter int unsigned UNIT_BYTES   = 512,
   parameter int unsigned D_MIN_BYTES  = 4096,
   parameter logic [31:0] D_KEEP       = 32'hFFFF_F03E,
   parameter logic [31:0] I_KEEP       = 32'h0000_003E,
   localparam int unsigned IOFF_W      = $clog2(I_PHYS_BYTES),
   localparam int unsigned DOFF_W      = $clog2(D_PHYS_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [31:0]       ctrl_wdata,
   input  logic              dset_wr,
   input  logic              iset_wr,
   input  logic [31:0]       set_wdata,
   input  logic              acc_valid,
   input  logic              acc_code,
   input  logic [1:0]        acc_size,
   input  logic [31:0]       acc_addr,
   output logic              itcm_hit,
   output logic              dtcm_hit,
   output logic [IOFF_W-1:0] itcm_off,
   output logic [DOFF_W-1:0] dtcm_off,
   output logic              one_cycle,
   output logic [31:0]       dset_q,
   output logic [31:0]       iset_q
);
   generate
      if ((I_PHYS_BYTES & (I_PHYS_BYTES - 1)) != 0 || I_PHYS_BYTES < 4) begin : g_bad_i
         $error("I_PHYS_BYTES must be a power of two of at least 4");
      end
      if ((D_PHYS_BYTES & (D_PHYS_BYTES - 1)) != 0 || D_PHYS_BYTES < 4) begin : g_bad_d
         $error("D_PHYS_BYTES must be a power of two of at least 4");
      end
      if (D_EN_BIT > 31 || I_EN_BIT > 31 || D_EN_BIT == I_EN_BIT) begin : g_bad_bits
         $error("enable bit positions must be distinct and below 32");
      end
      if ((D_MIN_BYTES & (D_MIN_BYTES - 1)) != 0) begin : g_bad_min
         $error("D_MIN_BYTES must be a power of two");
      end
   endgenerate

   logic  den_q, ien_q, den_n, ien_n;
   addr_t dset_n, iset_n;
   win_t  dwin_n, iwin_n, dwin_q, iwin_q;
   addr_t a_al;
   logic  i_in, d_in;

   assign den_n  = ctrl_wr ? ctrl_wdata[D_EN_BIT] : den_q;
   assign ien_n  = ctrl_wr ? ctrl_wdata[I_EN_BIT] : ien_q;
   assign dset_n = dset_wr ? (set_wdata & D_KEEP) : dset_q;
   assign iset_n = iset_wr ? (set_wdata & I_KEEP) : iset_q;

   tcm_geom #(
      .IS_DATA(1'b1), .UNIT_BYTES(UNIT_BYTES), .MIN_BYTES(D_MIN_BYTES),
      .FIELD_LSB(1), .FIELD_W(5)
   ) u_dgeom (
      .en_i(den_n), .setting_i(dset_n), .win_o(dwin_n)
   );

   tcm_geom #(
      .IS_DATA(1'b0), .UNIT_BYTES(UNIT_BYTES), .MIN_BYTES(D_MIN_BYTES),
      .FIELD_LSB(1), .FIELD_W(5)
   ) u_igeom (
      .en_i(ien_n), .setting_i(iset_n), .win_o(iwin_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         den_q       <= 1'b0;
         ien_q       <= 1'b0;
         dset_q      <= '0;
         iset_q      <= '0;
         dwin_q.base <= '1;
         dwin_q.mask <= '0;
         dwin_q.limit<= '0;
         iwin_q      <= '0;
      end else begin
         den_q  <= den_n;
         ien_q  <= ien_n;
         dset_q <= dset_n;
         iset_q <= iset_n;
         if (ctrl_wr || dset_wr) dwin_q <= dwin_n;
         if (ctrl_wr || iset_wr) iwin_q <= iwin_n;
      end
   end

   tcm_align u_align (
      .addr_i(acc_addr), .size_i(acc_size), .addr_o(a_al)
   );

   assign i_in = a_al < iwin_q.limit;
   assign d_in = (a_al & dwin_q.mask) == dwin_q.base;

   assign itcm_hit  = acc_valid && i_in;
   assign dtcm_hit  = acc_valid && !acc_code && !i_in && d_in;
   assign one_cycle = itcm_hit || dtcm_hit;
   assign itcm_off  = a_al[IOFF_W-1:0];
   assign dtcm_off  = a_al[DOFF_W-1:0];
endmodule

// File: rtl/tcm_decoder_chk.sv
module tcm_decoder_chk #(
   parameter int unsigned IOFF_W = 15,
   parameter int unsigned DOFF_W = 14,
   parameter logic [31:0] D_KEEP = 32'hFFFF_F03E,
   parameter logic [31:0] I_KEEP = 32'h0000_003E
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dset_wr,
   input logic              iset_wr,
   input logic [31:0]       set_wdata,
   input logic              acc_valid,
   input logic              acc_code,
   input logic [1:0]        acc_size,
   input logic              itcm_hit,
   input logic              dtcm_hit,
   input logic [IOFF_W-1:0] itcm_off,
   input logic [DOFF_W-1:0] dtcm_off,
   input logic              one_cycle,
   input logic [31:0]       dset_q,
   input logic [31:0]       iset_q
);
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(itcm_hit && dtcm_hit));

   p_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_code) |-> !dtcm_hit);

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!one_cycle && !itcm_hit && !dtcm_hit));

   p_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
      one_cycle |-> (itcm_hit || dtcm_hit));

   p_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_size == 2'd2 && itcm_hit) |-> (itcm_off[1:0] == 2'b00));

   p_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_size == 2'd1 && dtcm_hit) |-> (dtcm_off[0] == 1'b0));

   p_dkeep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dset_wr |=> (dset_q == ($past(set_wdata) & D_KEEP)));

   p_ikeep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      iset_wr |=> (iset_q == ($past(set_wdata) & I_KEEP)));
endmodule

bind tcm_decoder tcm_decoder_chk #(
   .IOFF_W(IOFF_W), .DOFF_W(DOFF_W), .D_KEEP(D_KEEP), .I_KEEP(I_KEEP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dset_wr(dset_wr), .iset_wr(iset_wr),
   .set_wdata(set_wdata), .acc_valid(acc_valid), .acc_code(acc_code),
   .acc_size(acc_size), .itcm_hit(itcm_hit), .dtcm_hit(dtcm_hit),
   .itcm_off(itcm_off), .dtcm_off(dtcm_off), .one_cycle(one_cycle),
   .dset_q(dset_q), .iset_q(iset_q)
);

// File: tb/tcm_decoder_bench.sv
module tcm_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic        dset_wr = 1'b0;
   logic        iset_wr = 1'b0;
   logic [31:0] set_wdata = '0;
   logic        acc_valid = 1'b0;
   logic        acc_code = 1'b0;
   logic [1:0]  acc_size = 2'd0;
   logic [31:0] acc_addr = '0;
   logic        itcm_hit, dtcm_hit, one_cycle;
   logic [14:0] itcm_off;
   logic [13:0] dtcm_off;
   logic [31:0] dset_q, iset_q;

   int total = 0;
   int bad = 0;

   localparam logic [31:0] CTL_D = 32'h0001_0000;
   localparam logic [31:0] CTL_I = 32'h0004_0000;

   always #5 clk = ~clk;

   tcm_decoder u_tcm_decoder (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .dset_wr(dset_wr), .iset_wr(iset_wr), .set_wdata(set_wdata),
      .acc_valid(acc_valid), .acc_code(acc_code), .acc_size(acc_size),
      .acc_addr(acc_addr), .itcm_hit(itcm_hit), .dtcm_hit(dtcm_hit),
      .itcm_off(itcm_off), .dtcm_off(dtcm_off), .one_cycle(one_cycle),
      .dset_q(dset_q), .iset_q(iset_q)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [31:0] v);
      @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_wr = 1'b0;
   endtask

   task automatic wr_dset(input logic [31:0] v);
      @(negedge clk); dset_wr = 1'b1; set_wdata = v;
      @(negedge clk); dset_wr = 1'b0;
   endtask

   task automatic wr_iset(input logic [31:0] v);
      @(negedge clk); iset_wr = 1'b1; set_wdata = v;
      @(negedge clk); iset_wr = 1'b0;
   endtask

   // present an access and check hits, offsets and the one-cycle flag
   task automatic probe(input string req, input logic code, input logic [1:0] sz,
                        input logic [31:0] a, input logic ei, input logic ed,
                        input logic [31:0] eoff);
      @(negedge clk);
      acc_valid = 1'b1; acc_code = code; acc_size = sz; acc_addr = a;
      #1;
      chk(req, {31'd0, itcm_hit}, {31'd0, ei});
      chk(req, {31'd0, dtcm_hit}, {31'd0, ed});
      chk({req, " R10"}, {31'd0, one_cycle}, {31'd0, ei | ed});
      if (ei) chk({req, " R7"}, {17'd0, itcm_off}, eoff);
      if (ed) chk({req, " R7"}, {18'd0, dtcm_off}, eoff);
   endtask

   task automatic t_reset;
      chk("reset R5", dset_q, 32'h0);
      chk("reset R5", iset_q, 32'h0);
      probe("reset R2", 1'b0, 2'd2, 32'h0, 1'b0, 1'b0, 0);
      probe("reset R4", 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 0);
   endtask

   task automatic t_instr_window;
      wr_ctrl(CTL_I);
      wr_iset(32'hFFFF_FF0A);
      chk("iset keep R5", iset_q, 32'h0000_000A);
      probe("i top R1", 1'b1, 2'd2, 32'h0000_3FFC, 1'b1, 1'b0, 32'h3FFC);
      probe("i limit R1", 1'b1, 2'd2, 32'h0000_4000, 1'b0, 1'b0, 0);
      wr_ctrl(32'h0);
      probe("i disabled R2", 1'b1, 2'd2, 32'h0000_0000, 1'b0, 1'b0, 0);
   endtask

   task automatic t_data_window;
      wr_ctrl(CTL_D);
      wr_dset(32'h0080_0A55);
      chk("dset keep R5", dset_q, 32'h0080_0014);
      probe("d mirror R7", 1'b0, 2'd0, 32'h0087_FFFF, 1'b0, 1'b1, 32'h3FFF);
      probe("d low R3", 1'b0, 2'd0, 32'h0080_0000, 1'b0, 1'b1, 32'h0);
      probe("d above R3", 1'b0, 2'd0, 32'h0088_0000, 1'b0, 1'b0, 0);
      probe("d below R3", 1'b0, 2'd0, 32'h007F_FFFF, 1'b0, 1'b0, 0);
   endtask

   task automatic t_data_clamp;
      wr_dset(32'h0200_5002);
      probe("clamp in R3", 1'b0, 2'd2, 32'h0200_5FFC, 1'b0, 1'b1, 32'h1FFC);
      probe("clamp over R3", 1'b0, 2'd2, 32'h0200_6000, 1'b0, 1'b0, 0);
      probe("clamp under R3", 1'b0, 2'd2, 32'h0200_4FFC, 1'b0, 1'b0, 0);
      wr_ctrl(32'h0);
      probe("d disabled R4", 1'b0, 2'd2, 32'h0200_5FFC, 1'b0, 1'b0, 0);
   endtask

   task automatic t_priority_code;
      wr_ctrl(CTL_I | CTL_D);
      wr_iset(32'h0000_000A);
      wr_dset(32'h0000_0006);
      probe("overlap data R6", 1'b0, 2'd2, 32'h0000_0100, 1'b1, 1'b0, 32'h100);
      probe("past i data R6", 1'b0, 2'd2, 32'h0000_4000, 1'b0, 1'b0, 0);
      wr_ctrl(CTL_D);
      probe("code in d R9", 1'b1, 2'd2, 32'h0000_0100, 1'b0, 1'b0, 0);
      probe("data in d R9", 1'b0, 2'd2, 32'h0000_0100, 1'b0, 1'b1, 32'h100);
   endtask

   task automatic t_align;
      wr_ctrl(CTL_I | CTL_D);
      wr_iset(32'h0);
      probe("byte R8", 1'b0, 2'd0, 32'h0000_01FF, 1'b1, 1'b0, 32'h1FF);
      probe("half R8", 1'b0, 2'd1, 32'h0000_01FF, 1'b1, 1'b0, 32'h1FE);
      probe("word R8", 1'b0, 2'd2, 32'h0000_01FF, 1'b1, 1'b0, 32'h1FC);
      probe("i edge R8", 1'b0, 2'd0, 32'h0000_0200, 1'b0, 1'b1, 32'h200);
      wr_dset(32'h0300_0000);
      probe("d half R8", 1'b0, 2'd1, 32'h0300_0FFF, 1'b0, 1'b1, 32'h0FFE);
   endtask

   task automatic t_overflow;
      wr_iset(32'h0000_002E);
      probe("i wrap R12", 1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0, 0);
      wr_dset(32'h0300_003E);
      probe("d wrap in R12", 1'b0, 2'd2, 32'h0300_0FFC, 1'b0, 1'b1, 32'h0FFC);
      probe("d wrap out R12", 1'b0, 2'd2, 32'h0300_1000, 1'b0, 1'b0, 0);
   endtask

   task automatic t_timing_idle;
      @(negedge clk);
      acc_valid = 1'b1; acc_code = 1'b0; acc_size = 2'd2; acc_addr = 32'h0500_0010;
      dset_wr = 1'b1; set_wdata = 32'h0500_0000;
      #1;
      chk("before edge R11", {31'd0, dtcm_hit}, 32'd0);
      @(posedge clk); #1;
      dset_wr = 1'b0;
      chk("after edge R11", {31'd0, dtcm_hit}, 32'd1);
      chk("after edge R10", {31'd0, one_cycle}, 32'd1);
      @(negedge clk);
      acc_valid = 1'b0;
      #1;
      chk("idle R10", {30'd0, itcm_hit, dtcm_hit}, 32'd0);
      chk("idle R10", {31'd0, one_cycle}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog R11 got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_instr_window();
      t_data_window();
      t_data_clamp();
      t_priority_code();
      t_align();
      t_overflow();
      t_timing_idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule